// File: doc/BRIEF.md
# Framed Request Register Bank

This block holds a small set of byte registers and serves them through two byte-wide streams. Each stream carries a valid/accept handshake plus first-beat and last-beat markers that delimit a packet. A request packet begins with a header byte. The low nibble of the header selects the operation and the high nibble selects the register. A write request adds one data byte after the header.

The controller checks the operation code and the framing of every request. A request it cannot serve is consumed and dropped, and no response is sent for it. A request it accepts gets a response packet. The response opens with a copy of the request header. A read response then carries one data byte. Every response closes with a status byte.

The controller handles one request at a time. It stops accepting request beats from the moment it takes a valid header until the last beat of the matching response has been taken.

Top module: `regpkt_ctrl`

## Requirements
- R1: While `rst_n` is low, `req_accept`, `rsp_valid`, `rsp_first` and `rsp_last` are low, and all eight registers are cleared. A read of any register after reset returns 0x00.
- R2: A request header has the operation in bits 3:0 and the register address in bits 7:4. Operation 0 reads and operation 1 writes. A header with any other operation is consumed and the controller returns to idle on the next cycle. No response beat is sent for it.
- R3: A read header must have both first and last set. A read header with last clear is dropped without a response, and the controller returns to idle on the next cycle.
- R4: A write header must have last clear, and its data beat must have first clear and last set. A write header with last set is dropped. A data beat with the wrong markers drops the whole request. In both cases no register changes and no response is sent.
- R5: An accepted read gets exactly three response beats, in this order:
  - a header beat with first=1, last=0 and the request header byte;
  - a data beat with first=0 and last=0;
  - a footer beat with first=0, last=1 and byte 0x00.
- R6: An accepted write gets exactly two response beats: the header beat (first=1, request header byte), then the footer beat (last=1).
- R7: A read data beat carries the addressed register for addresses 0 to 7, and 0x00 for addresses 8 to 15.
- R8: An accepted write to addresses 0 to 7 stores the data byte in that register. The register holds the new value one cycle after the internal commit, so every later read returns it. The write footer is 0x00.
- R9: A write to addresses 8 to 15 leaves every register unchanged, and its footer byte is 0x01.
- R10: `rsp_first` and `rsp_last` are never high together, and neither one is high while `rsp_valid` is low.
- R11: While `rsp_valid` is high and `rsp_accept` is low, `rsp_valid`, `rsp_first`, `rsp_last` and `rsp_byte` hold their values on the next cycle.
- R12: `req_accept` is low whenever `rsp_valid` is high. A new request is taken only after the footer of the previous response has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat present |
| req_accept | output | 1 | Controller takes the request beat at this edge |
| req_first | input | 1 | Request beat is the header |
| req_last | input | 1 | Request beat closes the packet |
| req_byte | input | 8 | Request header or data byte |
| rsp_valid | output | 1 | Response beat present |
| rsp_accept | input | 1 | Sink takes the response beat at this edge |
| rsp_first | output | 1 | Response beat is the header |
| rsp_last | output | 1 | Response beat is the status footer |
| rsp_byte | output | 8 | Header echo, read data or status byte |

## Verification
Timing from the last accepted request beat:
- Read: the response header appears in the cycle right after the read header is taken.
- Write: the data beat is taken, the next cycle commits the register, and the response header appears in the cycle after that.
- Later beats: each following beat appears in the cycle after the previous beat is accepted.
- Drops: after a dropped header, `req_accept` goes low for one idle cycle and then high again.

Because back-pressure makes these delays uneven, the checks do not wait a fixed number of cycles. The driver queues each expected beat when it issues the request. The monitor samples at the falling edge and pops an entry only in a cycle where valid and accept are both high. It also checks that a beat that is not yet accepted stays unchanged into the next cycle. A dropped request leaves nothing in the queue, so any stray beat shows up as an unexpected pop. The effect of a drop on the registers is confirmed by later reads.

// File: rtl/regpkt_pkg.sv
package regpkt_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int ADDR_W = BYTE_W - OP_W;

  localparam logic [OP_W-1:0] OP_RD = 4'h0;
  localparam logic [OP_W-1:0] OP_WR = 4'h1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_HDR,
    ST_GET_DAT,
    ST_SET_DAT,
    ST_SEND_HDR,
    ST_SEND_DAT,
    ST_SEND_FTR
  } ctl_state_e;

  function automatic logic [OP_W-1:0] hdr_op(input logic [BYTE_W-1:0] h);
    return h[OP_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_addr(input logic [BYTE_W-1:0] h);
    return h[BYTE_W-1:OP_W];
  endfunction

  function automatic logic addr_ok(input logic [ADDR_W-1:0] a, input int nreg);
    return int'(a) < nreg;
  endfunction

  // framing rule: a read is a single beat, a write header is never the last beat
  function automatic logic hdr_legal(input logic [BYTE_W-1:0] h, input logic last);
    if (hdr_op(h) == OP_RD) return last;
    if (hdr_op(h) == OP_WR) return !last;
    return 1'b0;
  endfunction

  function automatic logic [BYTE_W-1:0] footer_code(input logic [BYTE_W-1:0] h, input int nreg);
    return (hdr_op(h) == OP_WR && !addr_ok(hdr_addr(h), nreg)) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/regpkt_bank.sv
module regpkt_bank
  import regpkt_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [NREG-1:0][BYTE_W-1:0] mem;
  logic                        wr_hit;

  assign wr_hit = we && addr_ok(waddr, NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                 mem[g] <= '0;
      else if (wr_hit && waddr == ADDR_W'(g))     mem[g] <= wdata;
    end

    p_write_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == ADDR_W'(g)) |=> mem[g] == $past(wdata));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == ADDR_W'(i)) rdata = mem[i];
  end

  p_oor_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr_ok(waddr, NREG)) |=> $stable(mem));
endmodule

// File: rtl/regpkt_fsm.sv
module regpkt_fsm
  import regpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_first,
  input  logic              req_last,
  input  logic [BYTE_W-1:0] req_byte,
  output logic              req_accept,
  input  logic              rsp_accept,
  output ctl_state_e        state,
  output logic [BYTE_W-1:0] hdr_q,
  output logic [BYTE_W-1:0] dat_q,
  output logic              wr_stb
);
  logic hdr_take, hdr_good, dat_take, dat_good;

  assign req_accept = (state == ST_GET_HDR) || (state == ST_GET_DAT);
  assign hdr_take   = (state == ST_GET_HDR) && req_valid && req_first;
  assign hdr_good   = hdr_legal(req_byte, req_last);
  assign dat_take   = (state == ST_GET_DAT) && req_valid;
  assign dat_good   = !req_first && req_last;
  assign wr_stb     = (state == ST_SET_DAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hdr_q <= '0;
      dat_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_GET_HDR;
        ST_GET_HDR:
          if (hdr_take) begin
            hdr_q <= req_byte;
            if (!hdr_good)                       state <= ST_IDLE;
            else if (hdr_op(req_byte) == OP_RD)  state <= ST_SEND_HDR;
            else                                 state <= ST_GET_DAT;
          end
        ST_GET_DAT:
          if (dat_take) begin
            if (dat_good) begin
              dat_q <= req_byte;
              state <= ST_SET_DAT;
            end else begin
              state <= ST_IDLE;
            end
          end
        ST_SET_DAT: state <= ST_SEND_HDR;
        ST_SEND_HDR:
          if (rsp_accept) state <= (hdr_op(hdr_q) == OP_RD) ? ST_SEND_DAT : ST_SEND_FTR;
        ST_SEND_DAT:
          if (rsp_accept) state <= ST_SEND_FTR;
        ST_SEND_FTR:
          if (rsp_accept) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_bad_op_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && hdr_op(req_byte) != OP_RD && hdr_op(req_byte) != OP_WR) |=> state == ST_IDLE);

  p_read_stop_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && hdr_op(req_byte) == OP_RD && !req_last) |=> state == ST_IDLE);

  p_write_stop_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && hdr_op(req_byte) == OP_WR && req_last) |=> state == ST_IDLE);

  p_bad_data_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_take && !dat_good) |=> (state == ST_IDLE && !wr_stb));
endmodule

// File: rtl/regpkt_rsp.sv
module regpkt_rsp
  import regpkt_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_e        state,
  input  logic [BYTE_W-1:0] hdr_q,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              rsp_valid,
  output logic              rsp_first,
  output logic              rsp_last,
  output logic [BYTE_W-1:0] rsp_byte
);
  always_comb begin
    rsp_valid = 1'b0;
    rsp_first = 1'b0;
    rsp_last  = 1'b0;
    rsp_byte  = '0;
    unique case (state)
      ST_SEND_HDR: begin rsp_valid = 1'b1; rsp_first = 1'b1; rsp_byte = hdr_q; end
      ST_SEND_DAT: begin rsp_valid = 1'b1; rsp_byte = rd_byte; end
      ST_SEND_FTR: begin rsp_valid = 1'b1; rsp_last = 1'b1; rsp_byte = footer_code(hdr_q, NREG); end
      default: ;
    endcase
  end

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_first && rsp_last));

  p_flags_need_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_first || rsp_last) |-> rsp_valid);
endmodule

// File: rtl/regpkt_ctrl.sv
module regpkt_ctrl
  import regpkt_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_accept,
  input  logic              req_first,
  input  logic              req_last,
  input  logic [BYTE_W-1:0] req_byte,
  output logic              rsp_valid,
  input  logic              rsp_accept,
  output logic              rsp_first,
  output logic              rsp_last,
  output logic [BYTE_W-1:0] rsp_byte
);
  ctl_state_e        state;
  logic [BYTE_W-1:0] hdr_q, dat_q, rd_byte;
  logic              wr_stb;

  regpkt_fsm u_fsm (
    .clk, .rst_n, .req_valid, .req_first, .req_last, .req_byte, .req_accept,
    .rsp_accept, .state, .hdr_q, .dat_q, .wr_stb
  );

  regpkt_bank #(.NREG(NREG)) u_bank (
    .clk, .rst_n, .we(wr_stb), .waddr(hdr_addr(hdr_q)), .wdata(dat_q),
    .raddr(hdr_addr(hdr_q)), .rdata(rd_byte)
  );

  regpkt_rsp #(.NREG(NREG)) u_rsp (
    .clk, .rst_n, .state, .hdr_q, .rd_byte,
    .rsp_valid, .rsp_first, .rsp_last, .rsp_byte
  );

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_accept) |=> (rsp_valid && $stable(rsp_first) && $stable(rsp_last)
                                    && $stable(rsp_byte)));

  p_single_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_accept);

  p_oor_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_first && !rsp_last && !addr_ok(hdr_addr(hdr_q), NREG)) |-> rsp_byte == '0);
endmodule

// File: tb/sim_regpkt_ctrl.sv
`timescale 1ns/1ps
module sim_regpkt_ctrl;
  localparam time CLK_P = 8ns;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_first = 1'b0, req_last = 1'b0;
  logic [7:0] req_byte = '0;
  logic       rsp_accept = 1'b0;
  logic       req_accept, rsp_valid, rsp_first, rsp_last;
  logic [7:0] rsp_byte;

  regpkt_ctrl u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [9:0] expq[$];   // {first, last, byte}
  logic [7:0] model[8];
  bit         finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put_beat(input logic f, input logic l, input logic [7:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_first = f; req_last = l; req_byte = b;
    forever begin
      if (req_accept) begin
        @(posedge clk);
        #1 req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [3:0] a);
    logic [7:0] h;
    h = {a, 4'h0};
    expq.push_back({2'b10, h});
    expq.push_back({2'b00, (a < 8) ? model[a[2:0]] : 8'h00});
    expq.push_back({2'b01, 8'h00});
    put_beat(1'b1, 1'b1, h);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] h;
    h = {a, 4'h1};
    expq.push_back({2'b10, h});
    expq.push_back({2'b01, (a < 8) ? 8'h00 : 8'h01});
    if (a < 8) model[a[2:0]] = d;
    put_beat(1'b1, 1'b0, h);
    put_beat(1'b0, 1'b1, d);
  endtask

  // back-pressure on the response stream
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      #1 rsp_accept = (k % 4 != 2) && (k % 7 != 3);
      k++;
    end
  end

  // monitor / scoreboard
  initial begin
    logic       hold = 0;
    logic [9:0] held = '0;
    logic [9:0] exp_b;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (rsp_valid) begin
          chk(!(rsp_first && rsp_last), "R10", {rsp_first, rsp_last}, 2'b00);
          chk(!req_accept, "R12", req_accept, 0);
        end else begin
          chk(!rsp_first && !rsp_last, "R10", {rsp_first, rsp_last}, 2'b00);
        end
        if (hold)
          chk(rsp_valid && {rsp_first, rsp_last, rsp_byte} == held, "R11",
              {rsp_valid, rsp_first, rsp_last, rsp_byte}, {1'b1, held});
        hold = 0;
        if (rsp_valid && rsp_accept) begin
          if (expq.size() == 0) begin
            chk(0, "R2/R3/R4 unexpected beat", {rsp_first, rsp_last, rsp_byte}, 0);
          end else begin
            exp_b = expq.pop_front();
            chk({rsp_first, rsp_last, rsp_byte} == exp_b, "R5/R6/R7/R8/R9 beat",
                {rsp_first, rsp_last, rsp_byte}, exp_b);
          end
        end else if (rsp_valid) begin
          hold = 1;
          held = {rsp_first, rsp_last, rsp_byte};
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!req_accept && !rsp_valid && !rsp_first && !rsp_last, "R1",
        {req_accept, rsp_valid, rsp_first, rsp_last}, 0);
    rst_n = 1'b1;
    // R1: all registers read 0 after reset
    for (int a = 0; a < 8; a++) do_read(4'(a));
    // R6 R8: fill registers
    for (int a = 0; a < 8; a++) do_write(4'(a), 8'(8'h5A + 8'(a * 17)));
    // R5 R8: read back
    for (int a = 7; a >= 0; a--) do_read(4'(a));
    // R7: out-of-range reads
    do_read(4'd8); do_read(4'd15); do_read(4'd11);
    // R9: out-of-range write, then confirm nothing moved
    do_write(4'd12, 8'hEE);
    for (int a = 0; a < 8; a++) do_read(4'(a));
    // R2: bad operation code dropped
    put_beat(1'b1, 1'b1, 8'h35);
    put_beat(1'b1, 1'b0, 8'h2F);
    do_read(4'd3);
    // R3: read header without last dropped
    put_beat(1'b1, 1'b0, 8'h20);
    do_read(4'd2);
    // R4: write header with last set dropped, register untouched
    put_beat(1'b1, 1'b1, 8'h41);
    do_read(4'd4);
    // R4: data beat with first set drops the write
    put_beat(1'b1, 1'b0, 8'h51);
    put_beat(1'b1, 1'b1, 8'hC3);
    do_read(4'd5);
    // R8: overwrite then read
    do_write(4'd5, 8'h00);
    do_write(4'd5, 8'hA7);
    do_read(4'd5);
    // drain
    begin
      int w = 0;
      while (expq.size() != 0 && w < 2000) begin @(negedge clk); w++; end
    end
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R5/R6 responses complete", expq.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule